// File: doc/BRIEF.md
# Quad SPI SRAM Burst Reader

The block fetches bursts of bytes from a serial SRAM that is already in four-line mode. A host raises a request with a 24-bit start address and a nonzero byte count. The block then lowers chip select and runs the SPI clock at half the system clock. It sends a read command and the address as nibbles on four lines, then releases the lines for two dummy clocks. After that it samples one data nibble per SPI clock and joins each pair of nibbles into a byte. The memory keeps incrementing its address for as long as the clock runs.

Every byte is put on a broadcast bus as a one-cycle valid strobe with the data. Any number of consumers can take the same byte in the same cycle. A one-cycle frame pulse marks the first byte of each burst, so listeners can align to the stream. Only this block drives chip select, the SPI clock, the command and the address. After a burst, chip select stays high for a guard time before another request is taken.

Top module: `qspi_burst_rd`

## Requirements
- R1: While reset is held and after it is released with no request: cs_no is 1, sclk_o is 0, dq_oe_o is 0, byte_vld_o is 0, frame_o is 0 and busy_o is 0.
- R2: A request (req_i high at a clock edge while busy_o is 0 and len_i nonzero) makes cs_no 0 and busy_o 1 in the next cycle. A request with len_i equal to 0, or one made while busy_o is 1, has no effect on any output.
- R3: While cs_no is 0, sclk_o alternates every system cycle and starts low in the first cycle after cs_no falls. dq_o and dq_oe_o change only in cycles where sclk_o has just gone low.
- R4: The first 8 SPI clocks carry the read command 8'hEB and then the start address, most significant nibble first, one nibble per clock on dq_o[3:0] with dq_oe_o high. dq_oe_o is 0 at all other times and is never 1 while cs_no is 1.
- R5: SPI clocks 8 and 9 (counted from 0) are dummy clocks with the lines released. The first data nibble is taken on the rising edge of clock 10.
- R6: dq_i is sampled when sclk_o rises. The first nibble of each pair is bits 7:4 of the byte and the second nibble is bits 3:0.
- R7: Each byte is presented for exactly one cycle with byte_vld_o high, in the cycle after the rising edge that captures its second nibble, so valid cycles are 4 system cycles apart. Byte j carries the memory contents at start address + j, modulo 2^24.
- R8: frame_o is 1 exactly in the valid cycle of the first byte of each burst and never without byte_vld_o.
- R9: cs_no rises after 10 + 2*len SPI clocks. busy_o then stays 1 for 2 more cycles with cs_no high, so chip select stays high for at least one SPI period before the next request is accepted.
- R10: sclk_o is 0 whenever cs_no is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Burst request, level |
| addr_i | input | 24 | Start byte address |
| len_i | input | LEN_W | Byte count, 0 ignored |
| busy_o | output | 1 | Burst or guard time in progress |
| cs_no | output | 1 | SRAM chip select, active low |
| sclk_o | output | 1 | SPI clock |
| dq_o | output | 4 | Command/address nibble to SRAM |
| dq_oe_o | output | 1 | Output enable for dq_o |
| dq_i | input | 4 | Data nibble from SRAM |
| byte_vld_o | output | 1 | Broadcast byte strobe |
| frame_o | output | 1 | First byte of burst marker |
| byte_o | output | 8 | Broadcast byte |

## Verification
The bench goes after the one-clock offsets that are easy to get wrong. If the dummy count is off by one, every byte comes out assembled from misaligned nibbles. If the nibble order is swapped, bytes come out with their halves exchanged. If the end count is off, chip select rises one SPI period early or late and the byte count changes. A burst that crosses the top of the 24-bit address space checks that the addresses wrap. A zero-length request and requests made during a burst must leave chip select untouched. A request held high continuously checks the guard gap between back-to-back bursts, which a design lacking it would close up to nothing.

// File: rtl/qspi_pkg.sv
package qspi_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_XFER, ST_GAP} seq_st_e;
  localparam int ADDR_W     = 24;
  localparam int CMD_CLKS   = 2;
  localparam int ADDR_CLKS  = ADDR_W / 4;
  localparam int DUMMY_CLKS = 2;
  localparam int HDR_CLKS   = CMD_CLKS + ADDR_CLKS;
  localparam int LEAD_CLKS  = HDR_CLKS + DUMMY_CLKS;
endpackage

// File: rtl/qspi_seq.sv
module qspi_seq
  import qspi_pkg::*;
#(
  parameter int LEN_W   = 8,
  parameter int GAP_CYC = 2,
  parameter int CNT_W   = LEN_W + 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [LEN_W-1:0]  len_i,
  output logic              busy_o,
  output logic              xfer_o,
  output logic              ph_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [ADDR_W-1:0] addr_q_o
);
  localparam int GAP_W = $clog2(GAP_CYC + 1);

  seq_st_e            st_q;
  logic               ph_q;
  logic [CNT_W-1:0]   cnt_q, last_clk;
  logic [GAP_W-1:0]   gap_q;
  logic [LEN_W-1:0]   len_q;
  logic [ADDR_W-1:0]  addr_q;
  logic               take;

  assign take     = (st_q == ST_IDLE) && req_i && (len_i != '0);
  assign last_clk = CNT_W'(LEAD_CLKS) + {CNT_W'(len_q), 1'b0} - CNT_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      ph_q   <= 1'b0;
      cnt_q  <= '0;
      gap_q  <= '0;
      len_q  <= '0;
      addr_q <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (take) begin
          st_q   <= ST_XFER;
          ph_q   <= 1'b0;
          cnt_q  <= '0;
          len_q  <= len_i;
          addr_q <= addr_i;
        end
        ST_XFER: begin
          ph_q <= ~ph_q;
          if (ph_q) begin
            if (cnt_q == last_clk) begin
              st_q  <= ST_GAP;
              gap_q <= '0;
            end else begin
              cnt_q <= cnt_q + CNT_W'(1);
            end
          end
        end
        ST_GAP: begin
          gap_q <= gap_q + GAP_W'(1);
          if (gap_q == GAP_W'(GAP_CYC - 1)) st_q <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o   = (st_q != ST_IDLE);
  assign xfer_o   = (st_q == ST_XFER);
  assign ph_o     = ph_q;
  assign cnt_o    = cnt_q;
  assign addr_q_o = addr_q;

  // R2
  busy_needs_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(req_i) && ($past(len_i) != '0));
  // R2
  len_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_o && $past(xfer_o)) |-> $stable(len_q) && $stable(addr_q));
endmodule

// File: rtl/qspi_tx.sv
module qspi_tx
  import qspi_pkg::*;
#(
  parameter logic [7:0] RD_CMD = 8'hEB,
  parameter int         CNT_W  = 11
) (
  input  logic              xfer_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [3:0]        dq_o,
  output logic              dq_oe_o
);
  localparam int HW = 8 + ADDR_W;
  localparam int NN = HW / 4;

  logic [HW-1:0] hdr;
  logic [3:0]    nib [NN];
  logic [$clog2(NN)-1:0] sel;

  assign hdr = {RD_CMD, addr_i};
  for (genvar g = 0; g < NN; g++) begin : g_nib
    assign nib[g] = hdr[HW-1-4*g -: 4];
  end

  assign sel     = cnt_i[$clog2(NN)-1:0];
  assign dq_oe_o = xfer_i && (cnt_i < CNT_W'(HDR_CLKS));
  assign dq_o    = dq_oe_o ? nib[sel] : 4'h0;
endmodule

// File: rtl/qspi_rx.sv
module qspi_rx (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cap_i,
  input  logic       lo_i,
  input  logic       first_i,
  input  logic [3:0] dq_i,
  output logic       vld_o,
  output logic       frame_o,
  output logic [7:0] byte_o
);
  logic [3:0] hi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q    <= '0;
      vld_o   <= 1'b0;
      frame_o <= 1'b0;
      byte_o  <= '0;
    end else begin
      vld_o   <= cap_i && lo_i;
      frame_o <= cap_i && lo_i && first_i;
      if (cap_i && !lo_i) hi_q <= dq_i;
      if (cap_i && lo_i) byte_o <= {hi_q, dq_i};
    end
  end

  // R8
  frame_has_vld_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_o |-> vld_o);
  // R7
  vld_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_o |=> !vld_o);
endmodule

// File: rtl/qspi_burst_rd.sv
module qspi_burst_rd
  import qspi_pkg::*;
#(
  parameter int         LEN_W   = 8,
  parameter int         GAP_CYC = 2,
  parameter logic [7:0] RD_CMD  = 8'hEB
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [LEN_W-1:0]  len_i,
  output logic              busy_o,
  output logic              cs_no,
  output logic              sclk_o,
  output logic [3:0]        dq_o,
  output logic              dq_oe_o,
  input  logic [3:0]        dq_i,
  output logic              byte_vld_o,
  output logic              frame_o,
  output logic [7:0]        byte_o
);
  localparam int CNT_W = LEN_W + 3;

  logic              xfer, ph;
  logic [CNT_W-1:0]  cnt, nib_idx;
  logic [ADDR_W-1:0] addr_q;
  logic              cap;

  qspi_seq #(.LEN_W(LEN_W), .GAP_CYC(GAP_CYC), .CNT_W(CNT_W)) u_seq (
    .clk_i, .rst_ni, .req_i, .addr_i, .len_i,
    .busy_o, .xfer_o(xfer), .ph_o(ph), .cnt_o(cnt), .addr_q_o(addr_q)
  );

  qspi_tx #(.RD_CMD(RD_CMD), .CNT_W(CNT_W)) u_tx (
    .xfer_i(xfer), .cnt_i(cnt), .addr_i(addr_q), .dq_o, .dq_oe_o
  );

  // capture at the edge that raises sclk in a data clock
  assign nib_idx = cnt - CNT_W'(LEAD_CLKS);
  assign cap     = xfer && !ph && (cnt >= CNT_W'(LEAD_CLKS));

  qspi_rx u_rx (
    .clk_i, .rst_ni, .cap_i(cap), .lo_i(nib_idx[0]),
    .first_i(nib_idx == CNT_W'(1)), .dq_i,
    .vld_o(byte_vld_o), .frame_o, .byte_o
  );

  assign cs_no  = !xfer;
  assign sclk_o = xfer && ph;

  // R10
  sclk_idle_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_no |-> !sclk_o);
  // R4
  oe_in_frame_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dq_oe_o |-> !cs_no);
  // R3
  sclk_toggle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_no && $past(!cs_no)) |-> (sclk_o != $past(sclk_o)));
  // R3
  dq_stable_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sclk_o && $past(!cs_no)) |-> $stable(dq_o) && $stable(dq_oe_o));
  // R9
  cs_guard_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cs_no) |=> cs_no && busy_o);
endmodule

// File: tb/qspi_burst_rd_tb_top.sv
module qspi_burst_rd_tb_top;
  localparam int CLK_T = 10;
  localparam int LEN_W = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0;
  logic [23:0] addr = '0;
  logic [LEN_W-1:0] len = '0;
  logic busy, cs_n, sclk, oe, vld, frame;
  logic [3:0] dqo;
  logic [3:0] dqi = 4'h0;
  logic [7:0] bo;

  int vectors = 0, miscompares = 0;
  int t = -1, m_len = 0;
  logic [23:0] m_addr = '0;
  bit done = 0;

  always #(CLK_T/2) clk = ~clk;

  qspi_burst_rd #(.LEN_W(LEN_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .addr_i(addr), .len_i(len),
    .busy_o(busy), .cs_no(cs_n), .sclk_o(sclk), .dq_o(dqo), .dq_oe_o(oe),
    .dq_i(dqi), .byte_vld_o(vld), .frame_o(frame), .byte_o(bo)
  );

  function automatic logic [7:0] mem_f(input logic [23:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ a[23:16] ^ 8'h3C;
  endfunction

  task automatic chk(input string r, input string what, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s %s t=%0d actual=%0h expected=%0h", r, what, t, act, exp);
    end
  endtask

  // serial SRAM model: takes command/address on rising edges, drives data after falling edges
  int n_rise = 0;
  logic [7:0]  d_cmd = '0;
  logic [23:0] d_adr = '0;
  always @(negedge cs_n) n_rise = 0;
  always @(posedge sclk) if (!cs_n) begin
    if (n_rise < 2) d_cmd = {d_cmd[3:0], dqo};
    else if (n_rise < 8) d_adr = {d_adr[19:0], dqo};
    n_rise++;
  end
  always @(negedge sclk) if (!cs_n && n_rise >= 10) begin
    automatic int k = n_rise - 10;
    automatic logic [7:0] b = mem_f(d_adr + 24'(k / 2));
    dqi = (k % 2 == 0) ? b[7:4] : b[3:0];
  end
  always @(posedge cs_n) if (rst_n && t > 0) begin
    chk("R4", "device cmd", int'(d_cmd), 8'hEB);
    chk("R4", "device addr", int'(d_adr), int'(m_addr));
  end

  // reference model: t counts cycles since acceptance
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) t = -1;
    else if (t < 0) begin
      if (req && len != 0) begin t = 1; m_len = int'(len); m_addr = addr; end
    end else begin
      t = t + 1;
      if (t == 2 * (10 + 2 * m_len) + 3) t = -1;
    end
  end

  always @(negedge clk) begin
    automatic int tend = 2 * (10 + 2 * m_len);
    automatic bit x = (t >= 1) && (t <= tend);
    automatic bit e_oe = (t >= 1) && (t <= 16);
    automatic bit e_vld = (t >= 24) && ((t - 24) % 4 == 0) && ((t - 24) / 4 < m_len);
    automatic logic [31:0] hdr = {8'hEB, m_addr};
    string rq;
    rq = (t < 0) ? (rst_n ? "R2" : "R1") : "R9";
    chk(rq, "cs_no", int'(cs_n), int'(!x));
    chk(rq, "busy_o", int'(busy), int'(t >= 1));
    chk("R3", "sclk_o", int'(sclk), int'(x && (t % 2 == 0)));
    chk("R4", "dq_oe_o", int'(oe), int'(e_oe));
    if (e_oe) chk("R4", "dq_o", int'(dqo), int'(hdr[31 - 4 * ((t - 1) / 2) -: 4]));
    chk("R7", "byte_vld_o", int'(vld), int'(e_vld));
    chk("R8", "frame_o", int'(frame), int'(t == 24));
    if (e_vld && vld) chk("R6", "byte_o", int'(bo), int'(mem_f(m_addr + 24'((t - 24) / 4))));
  end

  task automatic burst(input logic [23:0] a, input int l);
    @(negedge clk);
    while (busy) @(negedge clk);
    req = 1'b1; addr = a; len = LEN_W'(l);
    @(negedge clk);
    req = 1'b0;
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 150000 && !done) begin
      done = 1;
      miscompares++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);  // R1 checked while in reset
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    burst(24'h000000, 1);       // R5 R6 single byte
    burst(24'h12345A, 4);       // R7 increment
    burst(24'hFFFFFE, 3);       // R7 wrap
    @(negedge clk);             // R2 zero length ignored
    req = 1'b1; addr = 24'h00AAAA; len = '0;
    repeat (4) @(negedge clk);
    req = 1'b0;
    repeat (2) @(negedge clk);
    @(negedge clk);             // R2 request during burst ignored
    req = 1'b1; addr = 24'h00ABCD; len = 8'd2;
    @(negedge clk);
    req = 1'b0;
    repeat (10) @(negedge clk);
    req = 1'b1; addr = 24'h777777; len = 8'd9;
    repeat (3) @(negedge clk);
    req = 1'b0;
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
    @(negedge clk);             // R9 held request, back-to-back guard
    req = 1'b1; addr = 24'h400000; len = 8'd2;
    repeat (2 * (2 * (10 + 4) + 3) + 2) @(negedge clk);
    req = 1'b0;
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
    burst(24'h0F0F0F, 64);
    burst(24'h800000, 255);     // R9 maximum count
    repeat (4) @(negedge clk);
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule